// File: doc/BRIEF.md
# Core Decrementer and Utilization Timer Unit

This unit supplies a processor core with three time-keeping registers that all advance on one shared timebase tick enable. Two of them are 32-bit down-counters: one serves the supervisor, the other the hypervisor. Each has its own interrupt request line. The third is a 64-bit up-counter that accumulates processor utilization. Software reaches all three through a small register port made of a 2-bit select, a write strobe, a write data bus and a combinational read data bus.

A decrementer can signal an event in two ways. The first is to count past zero: the register wraps to all ones, keeps counting, and flags an event. The second is a software write that turns a non-negative value (bit 31 clear) into a negative one (bit 31 set); that write flags an event at once. Every event moves that decrementer's interrupt state machine from `IRQ_IDLE` to `IRQ_PEND`. Pulsing the matching clear input returns it from `IRQ_PEND` to `IRQ_IDLE`. An event that arrives in the same cycle as a clear keeps the machine in `IRQ_PEND`. A reset, or a pulse on the timebase re-initialise input, forces both machines to `IRQ_IDLE`, loads both decrementers with all ones and clears the utilization counter.

Top module: `core_timer_unit`

## Requirements
- R1: On a cycle with `tb_tick` high, and with no write to it and no re-initialise, each decrementer becomes its previous value minus one after the clock edge.
- R2: A decrementer at 0 that takes a tick becomes 0xFFFFFFFF and its interrupt request is high in the next cycle.
- R3: A write whose data has bit 31 set, to a decrementer whose current bit 31 is clear, loads the data and sets that decrementer's interrupt request in the next cycle.
- R4: A write with any other combination of the written and current bit 31 loads the data and leaves the interrupt request unchanged.
- R5: The supervisor decrementer (select 0) drives only `sv_irq`, and the hypervisor decrementer (select 1) drives only `hv_irq`. An event on one leaves the other's value and request untouched.
- R6: After reset, and in the cycle after `tb_reinit` is high, both decrementers read 0xFFFFFFFF, the utilization counter reads 0 and both interrupt requests are low. Re-initialise takes priority over a write in the same cycle.
- R7: The utilization counter is 64 bits wide. A write with select 2 loads bits 31:0 and a write with select 3 loads bits 63:32; the other half is kept. On every tick without such a write it increments by one, carrying from the low half into the high half.
- R8: `reg_rdata` returns the current value of the selected register combinationally: select 0 gives the supervisor decrementer, 1 the hypervisor decrementer, 2 the utilization low half and 3 the utilization high half.
- R9: An interrupt request stays high until its clear input is pulsed. It goes low in the next cycle unless a new event occurs in that same cycle, in which case it stays high.
- R10: When a write and a tick fall in the same cycle, the written register takes the written value and the tick is ignored for that register only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_tick | input | 1 | Timebase tick enable, one cycle per tick |
| tb_reinit | input | 1 | Timebase re-initialise pulse |
| reg_sel | input | 2 | Register select (0 supervisor, 1 hypervisor, 2 utilization low, 3 utilization high) |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sv_irq_clr | input | 1 | Clear pulse for the supervisor interrupt request |
| hv_irq_clr | input | 1 | Clear pulse for the hypervisor interrupt request |
| sv_irq | output | 1 | Supervisor decrementer interrupt request (level) |
| hv_irq | output | 1 | Hypervisor decrementer interrupt request (level) |

## Verification
Every tick, write, clear and re-initialise takes effect at the first clock edge that samples it. The new register value and the new request level can therefore be seen one cycle after the stimulus is applied, and the read bus shows that value in the same cycle that the select is set. The bench applies each stimulus just after a rising edge and holds it across exactly one edge. It then sets the select to the register under observation and queues the expected read value and request levels. The monitor compares them at the following falling edge, when every register output has settled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        SEL_SV      = 2'd0,
        SEL_HV      = 2'd1,
        SEL_UTIL_LO = 2'd2,
        SEL_UTIL_HI = 2'd3
    } tmr_sel_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/tmr_dec_slice.sv
module tmr_dec_slice #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reinit,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         irq_clr,
    output logic [W-1:0] value,
    output logic         irq
);
    import tmr_pkg::*;

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    irq_state_e  state_q, state_d;
    logic [W-1:0] value_d;
    logic         event_w;
    logic         sign_up;
    logic         underflow;

    // write that turns a non-negative count into a negative one
    assign sign_up   = wr && wdata[W-1] && !value[W-1];
    // a tick taken at zero, with no write competing for the register
    assign underflow = !wr && tick && (value == '0);
    assign event_w   = !reinit && (sign_up || underflow);

    always_comb begin
        value_d = value;
        if (reinit)    value_d = ALL_ONES;
        else if (wr)   value_d = wdata;
        else if (tick) value_d = value - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value <= ALL_ONES;
        else        value <= value_d;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (event_w) state_d = IRQ_PEND;
            IRQ_PEND: if (reinit || (irq_clr && !event_w)) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_PEND: irq = 1'b1;
            default:  irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_util_ctr.sv
module tmr_util_ctr #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [2*HALF_W-1:0] count
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] count_d;

    always_comb begin
        count_d = count;
        if (reinit)     count_d = '0;
        else if (wr_lo) count_d = {count[FULL_W-1:HALF_W], wdata};
        else if (wr_hi) count_d = {wdata, count[HALF_W-1:0]};
        else if (tick)  count_d = count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_d;
    end
endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tb_tick,
    input  logic              tb_reinit,
    input  logic [1:0]        reg_sel,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sv_irq_clr,
    input  logic              hv_irq_clr,
    output logic              sv_irq,
    output logic              hv_irq
);
    import tmr_pkg::*;

    localparam int N_DEC  = 2;
    localparam int UTIL_W = 2 * DATA_W;

    logic [DATA_W-1:0] dec_val [N_DEC];
    logic [N_DEC-1:0]  dec_irq;
    logic [N_DEC-1:0]  dec_clr;
    logic [UTIL_W-1:0] util_val;
    logic [DATA_W-1:0] sv_val;
    logic [DATA_W-1:0] hv_val;

    assign dec_clr = {hv_irq_clr, sv_irq_clr};

    generate
        for (genvar g = 0; g < N_DEC; g++) begin : g_dec
            tmr_dec_slice #(.W(DATA_W)) u_dec (
                .clk     (clk),
                .rst_n   (rst_n),
                .reinit  (tb_reinit),
                .tick    (tb_tick),
                .wr      (reg_we && (reg_sel == 2'(g))),
                .wdata   (reg_wdata),
                .irq_clr (dec_clr[g]),
                .value   (dec_val[g]),
                .irq     (dec_irq[g])
            );
        end
    endgenerate

    tmr_util_ctr #(.HALF_W(DATA_W)) u_util (
        .clk    (clk),
        .rst_n  (rst_n),
        .reinit (tb_reinit),
        .tick   (tb_tick),
        .wr_lo  (reg_we && (reg_sel == SEL_UTIL_LO)),
        .wr_hi  (reg_we && (reg_sel == SEL_UTIL_HI)),
        .wdata  (reg_wdata),
        .count  (util_val)
    );

    assign sv_val = dec_val[0];
    assign hv_val = dec_val[1];
    assign sv_irq = dec_irq[0];
    assign hv_irq = dec_irq[1];

    always_comb begin
        unique case (tmr_sel_e'(reg_sel))
            SEL_SV:      reg_rdata = sv_val;
            SEL_HV:      reg_rdata = hv_val;
            SEL_UTIL_LO: reg_rdata = util_val[DATA_W-1:0];
            SEL_UTIL_HI: reg_rdata = util_val[UTIL_W-1:DATA_W];
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tb_tick,
    input logic                tb_reinit,
    input logic [1:0]          reg_sel,
    input logic                reg_we,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                sv_irq_clr,
    input logic                sv_irq,
    input logic                hv_irq,
    input logic [DATA_W-1:0]   sv_val,
    input logic [DATA_W-1:0]   hv_val,
    input logic [2*DATA_W-1:0] util_val
);
    logic sv_wr, hv_wr, util_wr;
    assign sv_wr   = reg_we && (reg_sel == 2'd0);
    assign hv_wr   = reg_we && (reg_sel == 2'd1);
    assign util_wr = reg_we && reg_sel[1];

    AST_SV_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_tick && !tb_reinit && !sv_wr) |=> (sv_val == $past(sv_val) - 1'b1)); // R1

    AST_SV_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_tick && !tb_reinit && !sv_wr && sv_val == '0) |=> (sv_val == '1 && sv_irq)); // R2

    AST_SV_SIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sv_wr && !tb_reinit && reg_wdata[DATA_W-1] && !sv_val[DATA_W-1]) |=> sv_irq); // R3

    AST_HV_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_tick && !tb_reinit && !hv_wr) |=> $stable(hv_val)); // R5

    AST_REINIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        tb_reinit |=> (sv_val == '1 && hv_val == '1 && util_val == '0 && !sv_irq && !hv_irq)); // R6

    AST_UTIL_TICK_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_tick && !tb_reinit && !util_wr) |=> (util_val == $past(util_val) + 1'b1)); // R7

    AST_SV_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sv_irq && !sv_irq_clr && !tb_reinit) |=> sv_irq); // R9

    AST_SV_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sv_wr && !tb_reinit) |=> (sv_val == $past(reg_wdata))); // R10
endmodule

bind core_timer_unit tmr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tb_tick    (tb_tick),
    .tb_reinit  (tb_reinit),
    .reg_sel    (reg_sel),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .sv_irq_clr (sv_irq_clr),
    .sv_irq     (sv_irq),
    .hv_irq     (hv_irq),
    .sv_val     (sv_val),
    .hv_val     (hv_val),
    .util_val   (util_val)
);

// File: tb/core_timer_unit_tb.sv
module core_timer_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_tick = 1'b0;
    logic        tb_reinit = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sv_irq_clr = 1'b0;
    logic        hv_irq_clr = 1'b0;
    logic        sv_irq;
    logic        hv_irq;

    always #4 clk = ~clk;

    core_timer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .tb_reinit(tb_reinit),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sv_irq_clr(sv_irq_clr), .hv_irq_clr(hv_irq_clr), .sv_irq(sv_irq), .hv_irq(hv_irq)
    );

    typedef struct {
        logic [31:0] data;
        logic        si;
        logic        hi;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 0;

    // reference state derived from the requirements
    logic [31:0] m_sv, m_hv;
    logic [63:0] m_util;
    logic        m_si, m_hi;

    task automatic model_reset();
        m_sv = '1; m_hv = '1; m_util = '0; m_si = 0; m_hi = 0;
    endtask

    task automatic push_obs(input logic [1:0] osel, input string tag);
        exp_t e;
        case (osel)
            2'd0:    e.data = m_sv;
            2'd1:    e.data = m_hv;
            2'd2:    e.data = m_util[31:0];
            default: e.data = m_util[63:32];
        endcase
        e.si = m_si; e.hi = m_hi; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(input logic tk, input logic we, input logic [1:0] wsel,
                        input logic [31:0] wd, input logic csv, input logic chv,
                        input logic re, input logic [1:0] osel, input string tag);
        logic ev_s, ev_h;
        @(posedge clk); #1;
        tb_tick = tk; reg_we = we; reg_sel = wsel; reg_wdata = wd;
        sv_irq_clr = csv; hv_irq_clr = chv; tb_reinit = re;
        @(posedge clk); #1;
        tb_tick = 0; reg_we = 0; sv_irq_clr = 0; hv_irq_clr = 0; tb_reinit = 0;
        reg_sel = osel;
        if (re) begin
            model_reset();
        end else begin
            ev_s = 0; ev_h = 0;
            if (we && wsel == 2'd0) begin ev_s = wd[31] && !m_sv[31]; m_sv = wd; end
            else if (tk) begin ev_s = (m_sv == 0); m_sv = m_sv - 1; end
            if (we && wsel == 2'd1) begin ev_h = wd[31] && !m_hv[31]; m_hv = wd; end
            else if (tk) begin ev_h = (m_hv == 0); m_hv = m_hv - 1; end
            if (we && wsel == 2'd2)      m_util[31:0]  = wd;
            else if (we && wsel == 2'd3) m_util[63:32] = wd;
            else if (tk)                 m_util = m_util + 1;
            m_si = ev_s ? 1'b1 : (csv ? 1'b0 : m_si);
            m_hi = ev_h ? 1'b1 : (chv ? 1'b0 : m_hi);
        end
        push_obs(osel, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (reg_rdata !== e.data || sv_irq !== e.si || hv_irq !== e.hi) begin
                n_fails++;
                $display("FAIL %s: rdata=%h sv_irq=%b hv_irq=%b expected rdata=%h sv_irq=%b hv_irq=%b",
                         e.tag, reg_rdata, sv_irq, hv_irq, e.data, e.si, e.hi);
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R6 reset values, R8 read mapping
        step(0,0,2'd0,0,0,0,0,2'd0,"R6 reset sv");
        step(0,0,2'd0,0,0,0,0,2'd1,"R6 reset hv");
        step(0,0,2'd0,0,0,0,0,2'd3,"R6 reset util hi");
        // R4 positive over negative: no irq
        step(0,1,2'd0,32'd5,0,0,0,2'd0,"R4 write positive");
        // R1 ticks
        for (int i = 0; i < 5; i++) step(1,0,2'd0,0,0,0,0,2'd0,"R1 tick down");
        step(0,0,2'd0,0,0,0,0,2'd1,"R1 hv ticked too");
        // R2 underflow, R5 only sv irq
        step(1,0,2'd0,0,0,0,0,2'd0,"R2 underflow wrap");
        step(0,0,2'd0,0,0,0,0,2'd1,"R5 hv unaffected");
        // R9 clear
        step(0,0,2'd0,0,1,0,0,2'd0,"R9 clear sv");
        step(0,0,2'd0,0,0,0,0,2'd0,"R9 stays low");
        // R3 sign change write
        step(0,1,2'd0,32'd10,0,0,0,2'd0,"R4 load 10");
        step(0,1,2'd0,32'h8000_0000,0,0,0,2'd0,"R3 negative write sv");
        step(0,0,2'd0,0,1,0,0,2'd0,"R9 clear again");
        // R4 negative over negative on hv
        step(0,1,2'd1,32'h8000_0001,0,0,0,2'd1,"R4 neg over neg hv");
        step(0,1,2'd1,32'd3,0,0,0,2'd1,"R4 pos over neg hv");
        step(0,1,2'd1,32'hF000_0000,0,0,0,2'd1,"R3 R5 negative write hv");
        step(0,0,2'd0,0,0,1,0,2'd1,"R9 clear hv");
        // R9 event in same cycle as clear
        step(0,1,2'd0,32'd0,0,0,0,2'd0,"R4 load zero");
        step(1,0,2'd0,0,1,0,0,2'd0,"R9 event beats clear");
        step(0,0,2'd0,0,1,0,0,2'd0,"R9 clear after");
        // R10 write with tick
        step(1,1,2'd0,32'd100,0,0,0,2'd0,"R10 write beats tick");
        step(0,0,2'd0,0,0,0,0,2'd1,"R10 hv still ticked");
        // R7 utilization halves and carry
        step(0,1,2'd2,32'hFFFF_FFFE,0,0,0,2'd2,"R7 load lo");
        step(0,1,2'd3,32'd1,0,0,0,2'd3,"R7 load hi");
        step(1,1,2'd2,32'hFFFF_FFFE,0,0,0,2'd2,"R10 util write beats tick");
        for (int i = 0; i < 3; i++) step(1,0,2'd0,0,0,0,0,2'd2,"R7 util tick");
        step(0,0,2'd0,0,0,0,0,2'd3,"R7 carry into hi");
        // R6 reinit wins over write and clears pending irq
        step(0,1,2'd0,32'h8000_0000,0,0,0,2'd0,"R3 set pending");
        step(0,1,2'd0,32'd7,0,0,1,2'd0,"R6 reinit sv");
        step(0,0,2'd0,0,0,0,0,2'd2,"R6 reinit util");
        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule